// File: doc/BRIEF.md
# MSI Termination Register Bank

This block is the landing point for message-signalled interrupts. Each such interrupt arrives as a posted write on a 32-bit memory-mapped slave port. The write address picks one pending register out of a bank of 16 groups with 8 registers each. The write data picks which of the 16 vector bits in that register to set. This gives 2048 distinct vectors in all.

Software services a group by first reading its summary register. The summary shows which of the group's eight registers hold anything. Software then reads those registers, and each read returns the pending bits and empties the register in the same access. Each group drives one level-sensitive interrupt line. The line stays high for as long as any register in that group is non-empty.

The write and read channels are separate and may both be active in the same cycle. Read data comes back one cycle after the request, together with a valid strobe.

Top module: `msi_term_bank`

## Requirements
- R1: After reset every pending bit is clear, all 16 interrupt outputs are low, and every mapped register reads zero.
- R2: A pending register of group g (0..15), slot i (0..7) sits at byte offset (g << 19) + (i << 16). Address bit 23 is 0 there and bits 15:0 are zero.
- R3: A write of value v (0..15) to a pending register sets bit v of that register. Bits already set stay set.
- R4: The summary register of group g sits at offset 0x800000 + (g << 16). Its bit x (0..7) is 1 exactly when slot x of that group holds a pending bit, and bits 31:8 read zero.
- R5: A read of a pending register returns its 16 bits in rd_data[15:0], with the upper bits zero, and clears the register. rd_data and rd_valid appear in the cycle after rd_en.
- R6: If a write and a read hit the same pending register in one cycle, the read returns the old contents and the register then holds only the newly written bit.
- R7: irq_out[g] is high exactly while summary register g is non-zero. It follows a set or a clear in the cycle after the access.
- R8: A write whose data is 16 or more, or whose address decodes to no pending register, changes nothing.
- R9: A read of an offset that is neither a pending register nor a summary register returns zero.
- R10: Summary registers are read-only, and a write to one has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Posted write strobe |
| wr_addr | input | 24 | Write byte offset within the bank |
| wr_data | input | 32 | Write data, the vector number |
| rd_en | input | 1 | Read request |
| rd_addr | input | 24 | Read byte offset within the bank |
| rd_data | output | 32 | Read data, valid one cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data as valid |
| irq_out | output | 16 | One level interrupt per group |

## Verification
An arriving interrupt write and a servicing read-to-clear can hit the same pending register in the same cycle. The bench provokes this by raising both strobes on one falling edge with identical addresses and a vector different from the one already pending. It then judges the result in two steps. The returned word must show only the earlier bit. A second read must show only the new bit. A further case aims the write at the neighbouring slot in the same cycle, and the summary afterwards must carry just that slot.

// File: rtl/msi_term_bank.sv
module msi_term_bank #(
  parameter int NGRP = 16,
  parameter int NIDX = 8,
  parameter int NVEC = 16,
  parameter int AW   = 24,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [NGRP-1:0] irq_out
);
  localparam int GW     = $clog2(NGRP);
  localparam int IW     = $clog2(NIDX);
  localparam int VW     = $clog2(NVEC);
  localparam int NREG   = NGRP * NIDX;
  localparam int RW     = GW + IW;
  localparam int SLOT_LO = 16;
  localparam int REG_HI  = SLOT_LO + RW;
  localparam int GRP_HI  = SLOT_LO + GW;

  logic [NVEC-1:0] pend [NREG];
  logic [NIDX-1:0] summ [NGRP];

  logic          wr_ok, rd_idx, rd_sum;
  logic [RW-1:0] wr_reg, rd_reg;
  logic [GW-1:0] rd_grp;
  logic [VW-1:0] wr_vec;

  assign wr_reg = wr_addr[REG_HI-1:SLOT_LO];
  assign rd_reg = rd_addr[REG_HI-1:SLOT_LO];
  assign rd_grp = rd_addr[GRP_HI-1:SLOT_LO];
  assign wr_vec = wr_data[VW-1:0];

  assign wr_ok  = wr_en && (wr_addr[AW-1:REG_HI] == '0) && (wr_addr[SLOT_LO-1:0] == '0)
                  && (wr_data < DW'(NVEC));
  assign rd_idx = rd_en && (rd_addr[AW-1:REG_HI] == '0) && (rd_addr[SLOT_LO-1:0] == '0);
  assign rd_sum = rd_en && rd_addr[AW-1] && (rd_addr[AW-2:GRP_HI] == '0)
                  && (rd_addr[SLOT_LO-1:0] == '0);

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n)
        pend[r] <= '0;
      else
        pend[r] <= ((rd_idx && rd_reg == RW'(r)) ? '0 : pend[r])
                 | ((wr_ok && wr_reg == RW'(r)) ? (NVEC'(1) << wr_vec) : '0);
    end
  end

  always_comb begin
    for (int g = 0; g < NGRP; g++)
      for (int i = 0; i < NIDX; i++)
        summ[g][i] = |pend[g*NIDX + i];
  end

  genvar gi;
  generate
    for (gi = 0; gi < NGRP; gi++) begin : g_irq
      assign irq_out[gi] = |summ[gi];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_idx)      rd_data <= DW'(pend[rd_reg]);
      else if (rd_sum) rd_data <= DW'(summ[rd_grp]);
      else             rd_data <= '0;
    end
  end

  assert_rdvalid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx && !(wr_ok && wr_reg == rd_reg)) |=> (pend[$past(rd_reg)] == '0));

  assert_collision_keeps_new_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx && wr_ok && wr_reg == rd_reg)
      |=> (pend[$past(wr_reg)] == (NVEC'(1) << $past(wr_vec))));

  assert_write_raises_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok |=> (irq_out != '0));

  assert_bad_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_ok && !rd_en) |=> $stable(irq_out));

  assert_unmapped_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_idx && !rd_sum) |=> (rd_data == '0));

endmodule

// File: tb/msi_term_bank_tb.sv
module msi_term_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [23:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [23:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  msi_term_bank dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .irq_out(irq_out)
  );

  function automatic logic [23:0] a_idx(int g, int i);
    return 24'((g << 19) | (i << 16));
  endfunction

  function automatic logic [23:0] a_sum(int g);
    return 24'(24'h800000 | (g << 16));
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [23:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
    if (rd_valid !== 1'b1) begin
      n_fail++;
      $display("FAIL R5: rd_valid got %b expected 1", rd_valid);
    end
  endtask

  task automatic rd_wr(logic [23:0] ra, logic [23:0] wa, logic [31:0] wd,
                       output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = ra; wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    d = rd_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 32'(irq_out), 0);
    rd(a_sum(0), d);    check("R1 summary", d, 0);
    rd(a_idx(3, 5), d); check("R1 index", d, 0);

    // R3: all sixteen vectors into one register
    for (int v = 0; v < 16; v++) wr(a_idx(2, 4), 32'(v));
    rd(a_sum(2), d);    check("R4 single summary", d, 32'h10);
    check("R7 single irq", 32'(irq_out), 32'h4);
    rd(a_idx(2, 4), d); check("R3 all vectors", d, 32'hFFFF);
    rd(a_idx(2, 4), d); check("R5 cleared", d, 0);
    check("R7 irq drop", 32'(irq_out), 0);

    // R2/R4/R5/R7: full sweep of the bank
    for (int g = 0; g < 16; g++)
      for (int i = 0; i < 8; i++) begin
        wr(a_idx(g, i), 32'((g + i) % 16));
        wr(a_idx(g, i), 32'((g*5 + i*3 + 1) % 16));
      end
    check("R7 all irq", 32'(irq_out), 32'hFFFF);
    for (int g = 0; g < 16; g++) begin
      rd(a_sum(g), d); check("R4 full summary", d, 32'hFF);
      for (int i = 0; i < 8; i++) begin
        logic [15:0] e;
        logic [7:0] m;
        e = 16'(1 << ((g + i) % 16)) | 16'(1 << ((g*5 + i*3 + 1) % 16));
        rd(a_idx(g, i), d); check("R2 R5 sweep read", d, 32'(e));
        m = 8'(9'h0FF << (i + 1));
        rd(a_sum(g), d); check("R4 summary after read", d, 32'(m));
      end
      check("R7 irq after group drain", 32'(irq_out), 32'(17'h1FFFF << (g + 1)) & 32'hFFFF);
    end

    // R4: sparse pattern
    for (int i = 1; i < 8; i += 2) wr(a_idx(7, i), 32'(i));
    wr(a_idx(0, 0), 32'd15);
    rd(a_sum(7), d); check("R4 sparse g7", d, 32'hAA);
    rd(a_sum(0), d); check("R4 sparse g0", d, 32'h01);
    check("R7 sparse irq", 32'(irq_out), 32'h81);
    for (int i = 1; i < 8; i += 2) begin
      rd(a_idx(7, i), d); check("R5 sparse read", d, 32'(1 << i));
    end
    rd(a_idx(0, 0), d); check("R5 sparse read g0", d, 32'h8000);
    check("R7 sparse cleared", 32'(irq_out), 0);

    // R8: ignored writes
    wr(a_idx(4, 1), 32'd16);
    wr(a_idx(4, 1), 32'h20);
    wr(a_idx(4, 1), 32'hFFFFFFFF);
    wr(24'h040001, 32'd3);
    wr(24'h900000, 32'd3);
    wr(24'hA00000, 32'd3);
    check("R8 irq unchanged", 32'(irq_out), 0);
    rd(a_idx(4, 1), d); check("R8 target untouched", d, 0);
    rd(a_idx(0, 0), d); check("R8 alias untouched", d, 0);

    // R10: summary is read-only
    wr(a_idx(3, 1), 32'd6);
    wr(a_sum(3), 32'd0);
    wr(a_sum(3), 32'd5);
    rd(a_sum(3), d); check("R10 summary kept", d, 32'h02);
    check("R10 irq", 32'(irq_out), 32'h8);
    rd(a_idx(3, 1), d); check("R10 pending kept", d, 32'h40);
    rd(a_idx(3, 0), d); check("R10 no set via summary", d, 0);

    // R9: unmapped reads
    wr(a_idx(0, 0), 32'd1);
    rd(24'h000004, d); check("R9 low offset", d, 0);
    rd(24'h900000, d); check("R9 past summaries", d, 0);
    rd(24'hFF0000, d); check("R9 top", d, 0);
    rd(a_idx(0, 0), d); check("R9 neighbour intact", d, 32'h2);

    // R6: read-to-clear and new write in the same cycle
    wr(a_idx(5, 2), 32'd3);
    rd_wr(a_idx(5, 2), a_idx(5, 2), 32'd9, d);
    check("R6 old value returned", d, 32'h0008);
    check("R6 irq stays", 32'(irq_out), 32'h20);
    rd(a_idx(5, 2), d); check("R6 new bit survives", d, 32'h0200);
    wr(a_idx(5, 2), 32'd0);
    rd_wr(a_idx(5, 2), a_idx(5, 3), 32'd4, d);
    check("R6 other slot read", d, 32'h1);
    rd(a_sum(5), d); check("R6 other slot summary", d, 32'h08);
    rd(a_idx(5, 3), d); check("R6 other slot value", d, 32'h10);
    check("R7 final irq", 32'(irq_out), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule